// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point words (1 sign bit, 8-bit biased exponent with bias 127, 23-bit fraction with a hidden leading one). It returns a 32-bit result that is rounded to nearest, with ties going to even. It also returns four exception flags. An operation select turns the second operand's sign around, so subtraction uses the same path as addition.

The datapath has two pipeline stages. The first stage decodes the operands and picks the operand with the larger exponent. It shifts the other significand right by the exponent gap, and keeps two extra low bits plus a sticky OR of everything shifted past them. It then adds or subtracts the 27-bit extended significands. A negative difference is turned back into a magnitude, and the sign is flipped to match. The second stage normalizes the sum in one of two ways: a one-place right shift when the sum carries out, or a left shift by the leading-zero count after cancellation. It then rounds, renormalizes if the rounding carries out, and classifies the result.

Operands with a zero exponent are treated as signed zeros. Results below the normal range are flushed to signed zero. A new operation can start on every cycle, and results come out in issue order.

Top module: `fpas_top`

## Requirements
- R1: For finite normal or zero operands, the result is the exact sum of the operand values rounded to the nearest representable normal value. The result word is laid out as sign at bit 31, biased exponent at bits 30:23 and fraction at bits 22:0.
- R2: When `opSub` is 1, the result equals `opA` plus `opB` with the sign bit of `opB` inverted.
- R3: Rounding is round-to-nearest with ties to the even fraction. `flagInx` is 1 exactly when any nonzero bit was discarded.
- R4: When rounding carries out of the significand, the result is renormalized and its exponent is incremented. For example, 0x3FFFFFFF plus 0x33800000 gives 0x40000000.
- R5: When the magnitude of the operand with the larger exponent is smaller than the magnitude of the other operand, the result takes the sign of the larger-magnitude operand.
- R6: An exact zero sum is +0 (0x00000000), except when both operands are zeros with the same effective sign, in which case the result keeps that sign.
- R7: A NaN operand (exponent 255 with a nonzero fraction) gives the quiet NaN 0x7FC00000, with all four flags at 0.
- R8: Adding two infinities of opposite effective sign gives 0x7FC00000 and sets `flagInv`. No other flag is set.
- R9: In all other cases, an infinite operand gives an infinity with that operand's effective sign, and no flags.
- R10: When the rounded exponent reaches 255 or more, the result is an infinity with the computed sign, and `flagOvf` and `flagInx` are set.
- R11: An operand with exponent 0 counts as a zero of its sign. When the normalized exponent is 0 or lower, the result is a zero with the computed sign, and `flagUnf` and `flagInx` are set.
- R12: Every accepted operation (`inVld` high at a rising edge) produces exactly one `outVld` pulse two rising edges later. Operations issued back to back come out in issue order.
- R13: After reset, `outVld`, `result` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inVld | input | 1 | Operands and opSub are valid this cycle |
| opSub | input | 1 | 1 = subtract opB from opA, 0 = add |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| outVld | output | 1 | Result and flags are valid this cycle |
| result | output | 32 | Rounded result word |
| flagOvf | output | 1 | Overflow |
| flagUnf | output | 1 | Underflow (result flushed to zero) |
| flagInv | output | 1 | Invalid operation |
| flagInx | output | 1 | Inexact |

## Verification
The result and all four flags of an operation registered at rising edge N show up together, with `outVld`, after rising edge N+2. The bench counts rising edges. For each operation it records the edge count at issue, and it samples the outputs on the falling edge. It then checks that each output pulse arrives exactly two edges after its own issue, and that the data matches the expected value queued in the same order. The expected values come from an exact wide-integer model of the sum, rounded in the bench. Random operand pairs with nearby exponents drive cancellation and alignment. Directed pairs cover ties, rounding carry, signed zeros, special values, overflow and underflow.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  localparam int ExpW   = 8;
  localparam int FracW  = 23;
  localparam int WordW  = 1 + ExpW + FracW;
  localparam int SigW   = FracW + 1;
  localparam int ExtW   = SigW + 3;
  localparam int SumW   = ExtW + 1;
  localparam int AlignW = SigW + ExtW - 1;
  localparam int ShMax  = ExtW - 1;
  localparam int ShW    = $clog2(ShMax + 1);
  localparam int LzW    = $clog2(ExtW + 1);
  localparam int ExpMax = (1 << ExpW) - 1;

  typedef struct packed {
    logic ldAlign;
    logic ldRound;
  } fpasStrobe_t;
endpackage

// File: rtl/fpas_rshift.sv
module fpas_rshift #(
  parameter int W  = 50,
  parameter int SW = 5
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [0:SW];
  assign stg[0] = din;
  for (genvar i = 0; i < SW; i++) begin : g_lvl
    assign stg[i+1] = amt[i] ? (stg[i] >> (1 << i)) : stg[i];
  end
  assign dout = stg[SW];
endmodule

// File: rtl/fpas_lzc.sv
module fpas_lzc #(
  parameter int W  = 27,
  parameter int CW = 5
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpas_ctrl.sv
module fpas_ctrl
  import fpas_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inVld,
  output fpasStrobe_t strb,
  output logic        outVld
);
  logic vldAlign;
  logic vldRound;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldAlign <= 1'b0;
      vldRound <= 1'b0;
    end else begin
      vldAlign <= inVld;
      vldRound <= vldAlign;
    end
  end

  assign strb.ldAlign = inVld;
  assign strb.ldRound = vldAlign;
  assign outVld       = vldRound;

  // R12
  issue_to_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    inVld |=> ##1 outVld);
  // R12
  out_has_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outVld) |-> $past(strb.ldRound));
endmodule

// File: rtl/fpas_datapath.sv
module fpas_datapath
  import fpas_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  fpasStrobe_t      strb,
  input  logic             opSub,
  input  logic [WordW-1:0] opA,
  input  logic [WordW-1:0] opB,
  output logic [WordW-1:0] result,
  output logic             flagOvf,
  output logic             flagUnf,
  output logic             flagInv,
  output logic             flagInx
);
  localparam logic [ShW-1:0]          ShCap  = ShW'(ShMax);
  localparam logic [ExpW-1:0]         ExpAll = ExpW'(ExpMax);
  localparam logic signed [ExpW+1:0]  ExpTop = (ExpW+2)'(ExpMax);
  localparam logic [WordW-1:0]        QNan   = {1'b0, ExpAll, 1'b1, {(FracW-1){1'b0}}};

  // ---------------- stage 1: decode, align, add ----------------
  logic sA, sB, nanA, nanB, infA, infB, swap, effSub, negSum;
  logic [ExpW-1:0]  eA, eB, eBig, eSml, eDiff;
  logic [FracW-1:0] fA, fB;
  logic [SigW-1:0]  sigA, sigB, sigBig, sigSml;
  logic [ShW-1:0]   shAmt;
  logic [AlignW-1:0] alignWide;
  logic [ExtW-1:0]  alignSml;
  logic [SumW:0]    opBig, opSml, rawSum, negVal;
  logic [SumW-1:0]  magSum;
  logic sBig;

  assign sA   = opA[WordW-1];
  assign sB   = opB[WordW-1] ^ opSub;
  assign eA   = opA[WordW-2 -: ExpW];
  assign eB   = opB[WordW-2 -: ExpW];
  assign fA   = opA[FracW-1:0];
  assign fB   = opB[FracW-1:0];
  assign nanA = (eA == ExpAll) && (fA != '0);
  assign nanB = (eB == ExpAll) && (fB != '0);
  assign infA = (eA == ExpAll) && (fA == '0);
  assign infB = (eB == ExpAll) && (fB == '0);
  assign sigA = (eA == '0) ? '0 : {1'b1, fA};
  assign sigB = (eB == '0) ? '0 : {1'b1, fB};

  assign swap   = eB > eA;
  assign eBig   = swap ? eB : eA;
  assign eSml   = swap ? eA : eB;
  assign sigBig = swap ? sigB : sigA;
  assign sigSml = swap ? sigA : sigB;
  assign sBig   = swap ? sB : sA;
  assign eDiff  = eBig - eSml;
  assign shAmt  = (eDiff > ExpW'(ShMax)) ? ShCap : eDiff[ShW-1:0];

  fpas_rshift #(.W(AlignW), .SW(ShW)) uAlign (
    .din ({sigSml, {(ExtW-1){1'b0}}}),
    .amt (shAmt),
    .dout(alignWide)
  );

  assign alignSml = {alignWide[AlignW-1 -: ExtW-1], |alignWide[SigW-1:0]};
  assign effSub   = sA ^ sB;
  assign opBig    = {2'b00, sigBig, {(ExtW-SigW){1'b0}}};
  assign opSml    = {2'b00, alignSml};
  assign rawSum   = effSub ? (opBig - opSml) : (opBig + opSml);
  assign negVal   = -rawSum;
  assign negSum   = rawSum[SumW];
  assign magSum   = negSum ? negVal[SumW-1:0] : rawSum[SumW-1:0];

  logic [SumW-1:0] s1Mag;
  logic [ExpW-1:0] s1Exp;
  logic s1Sign, s1Nan, s1Inv, s1Inf, s1InfSign, s1ZeroSign;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Mag <= '0; s1Exp <= '0; s1Sign <= 1'b0; s1Nan <= 1'b0;
      s1Inv <= 1'b0; s1Inf <= 1'b0; s1InfSign <= 1'b0; s1ZeroSign <= 1'b0;
    end else if (strb.ldAlign) begin
      s1Mag      <= magSum;
      s1Exp      <= eBig;
      s1Sign     <= sBig ^ negSum;
      s1Nan      <= nanA | nanB | (infA & infB & effSub);
      s1Inv      <= infA & infB & effSub & ~nanA & ~nanB;
      s1Inf      <= infA | infB;
      s1InfSign  <= infA ? sA : sB;
      s1ZeroSign <= effSub ? 1'b0 : sA;
    end
  end

  // ---------------- stage 2: normalize, round, classify ----------------
  logic [LzW-1:0]  lzCnt;
  logic [ExtW-1:0] normR, normL, norm;
  logic carryOut, m0, rBit, stBit, roundUp, rndCarry;
  logic [SigW:0]   rnd;
  logic [SigW-1:0] sigF;
  logic signed [ExpW+1:0] expN, expF;

  fpas_lzc #(.W(ExtW), .CW(LzW)) uLzc (
    .vec(s1Mag[ExtW-1:0]),
    .cnt(lzCnt)
  );

  assign carryOut = s1Mag[SumW-1];
  assign normR    = {s1Mag[SumW-1:2], s1Mag[1] | s1Mag[0]};
  assign normL    = s1Mag[ExtW-1:0] << lzCnt;
  assign norm     = carryOut ? normR : normL;
  assign expN     = carryOut ? ($signed({2'b00, s1Exp}) + 10'sd1)
                             : ($signed({2'b00, s1Exp}) - $signed({{(ExpW+2-LzW){1'b0}}, lzCnt}));
  assign m0       = norm[3];
  assign rBit     = norm[2];
  assign stBit    = |norm[1:0];
  assign roundUp  = rBit & (m0 | stBit);
  assign rnd      = {1'b0, norm[ExtW-1:3]} + {{SigW{1'b0}}, roundUp};
  assign rndCarry = rnd[SigW];
  assign sigF     = rndCarry ? rnd[SigW:1] : rnd[SigW-1:0];
  assign expF     = expN + {{(ExpW+1){1'b0}}, rndCarry};

  logic [WordW-1:0] resN;
  logic ovfN, unfN, invN, inxN;

  always_comb begin
    resN = {s1Sign, expF[ExpW-1:0], sigF[FracW-1:0]};
    ovfN = 1'b0; unfN = 1'b0; invN = 1'b0; inxN = rBit | stBit;
    if (s1Nan) begin
      resN = QNan; invN = s1Inv; inxN = 1'b0;
    end else if (s1Inf) begin
      resN = {s1InfSign, ExpAll, {FracW{1'b0}}}; inxN = 1'b0;
    end else if (s1Mag == '0) begin
      resN = {s1ZeroSign, {(WordW-1){1'b0}}}; inxN = 1'b0;
    end else if (expF <= 0) begin
      resN = {s1Sign, {(WordW-1){1'b0}}}; unfN = 1'b1; inxN = 1'b1;
    end else if (expF >= ExpTop) begin
      resN = {s1Sign, ExpAll, {FracW{1'b0}}}; ovfN = 1'b1; inxN = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0; flagOvf <= 1'b0; flagUnf <= 1'b0; flagInv <= 1'b0; flagInx <= 1'b0;
    end else if (strb.ldRound) begin
      result <= resN; flagOvf <= ovfN; flagUnf <= unfN; flagInv <= invN; flagInx <= inxN;
    end
  end

  // R10
  ovf_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagOvf |-> (result[WordW-2:0] == {ExpAll, {FracW{1'b0}}}) && flagInx);
  // R11
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagUnf |-> (result[WordW-2:0] == '0) && flagInx);
  // R11
  no_denorm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (result[WordW-2 -: ExpW] == '0) |-> (result[FracW-1:0] == '0));
  // R8
  inv_nan_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagInv |-> (result == QNan) && !flagInx && !flagOvf);
  // R7
  nan_prop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ldRound && s1Nan) |=> (result == QNan));
  // R3
  one_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({flagOvf, flagUnf, flagInv}) <= 1);
endmodule

// File: rtl/fpas_top.sv
module fpas_top
  import fpas_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inVld,
  input  logic             opSub,
  input  logic [WordW-1:0] opA,
  input  logic [WordW-1:0] opB,
  output logic             outVld,
  output logic [WordW-1:0] result,
  output logic             flagOvf,
  output logic             flagUnf,
  output logic             flagInv,
  output logic             flagInx
);
  fpasStrobe_t strb;

  fpas_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .inVld (inVld),
    .strb  (strb),
    .outVld(outVld)
  );

  fpas_datapath uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .opSub  (opSub),
    .opA    (opA),
    .opB    (opB),
    .result (result),
    .flagOvf(flagOvf),
    .flagUnf(flagUnf),
    .flagInv(flagInv),
    .flagInx(flagInx)
  );
endmodule

// File: tb/fpas_top_test.sv
`timescale 1ns/1ps
module fpas_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inVld = 1'b0;
  logic opSub = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic outVld, flagOvf, flagUnf, flagInv, flagInx;
  logic [31:0] result;

  always #4 clk = ~clk;

  fpas_top uut (
    .clk(clk), .rstN(rstN), .inVld(inVld), .opSub(opSub), .opA(opA), .opB(opB),
    .outVld(outVld), .result(result), .flagOvf(flagOvf), .flagUnf(flagUnf),
    .flagInv(flagInv), .flagInx(flagInx)
  );

  int checks = 0;
  int fails = 0;
  int posCnt = 0;
  int wrIdx = 0;
  int rdIdx = 0;
  bit done = 0;
  logic [35:0] expQ [0:4095];
  int          drvQ [0:4095];
  string       tagQ [0:4095];

  always @(posedge clk) posCnt <= posCnt + 1;

  // exact wide-integer model; flags packed as {ovf, unf, inv, inx}
  function automatic logic [35:0] refAdd(input logic [31:0] a, input logic [31:0] b, input logic sub);
    logic sa, sb, sg, r, st, up;
    logic [7:0] ea, eb;
    logic [22:0] fa, fb;
    logic [299:0] ia, ib, s, lowMask;
    logic [23:0] sig;
    logic [24:0] sig25;
    int k, e;
    sa = a[31]; sb = b[31] ^ sub;
    ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
    if ((ea == 8'hFF && fa != 0) || (eb == 8'hFF && fb != 0)) return {32'h7FC00000, 4'b0000};
    if (ea == 8'hFF && eb == 8'hFF)
      return (sa != sb) ? {32'h7FC00000, 4'b0010} : {sa, 8'hFF, 23'd0, 4'b0000};
    if (ea == 8'hFF) return {sa, 8'hFF, 23'd0, 4'b0000};
    if (eb == 8'hFF) return {sb, 8'hFF, 23'd0, 4'b0000};
    ia = (ea == 0) ? 300'd0 : (300'({1'b1, fa}) << ea);
    ib = (eb == 0) ? 300'd0 : (300'({1'b1, fb}) << eb);
    if (sa == sb) begin s = ia + ib; sg = sa; end
    else if (ia >= ib) begin s = ia - ib; sg = sa; end
    else begin s = ib - ia; sg = sb; end
    if (s == 0) return {(sa == sb) ? sa : 1'b0, 31'd0, 4'b0000};
    k = 0;
    for (int i = 0; i < 300; i++) if (s[i]) k = i;
    e = k - 23;
    if (e <= 0) return {sg, 31'd0, 4'b0101};
    sig = 24'(s >> e);
    r = s[e-1];
    lowMask = (300'd1 << (e - 1)) - 300'd1;
    st = (s & lowMask) != 0;
    up = r & (sig[0] | st);
    sig25 = {1'b0, sig} + {24'd0, up};
    if (sig25[24]) begin e = e + 1; sig25 = sig25 >> 1; end
    if (e >= 255) return {sg, 8'hFF, 23'd0, 4'b1001};
    return {sg, 8'(e), sig25[22:0], 3'b000, r | st};
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic sub,
                       input logic [35:0] expv, input string tag);
    @(negedge clk);
    inVld = 1'b1; opA = a; opB = b; opSub = sub;
    expQ[wrIdx] = expv; drvQ[wrIdx] = posCnt; tagQ[wrIdx] = tag;
    wrIdx = wrIdx + 1;
  endtask

  task automatic idle();
    @(negedge clk);
    inVld = 1'b0;
  endtask

  // output monitor: data and arrival edge (R12)
  always @(negedge clk) begin
    if (rstN && outVld && !done) begin
      checks++;
      if (rdIdx >= wrIdx) begin
        fails++;
        $display("FAIL R12 unexpected outVld: actual 1 expected 0");
      end else begin
        if (posCnt != drvQ[rdIdx] + 2) begin
          fails++;
          $display("FAIL R12 vector %0d latency: actual %0d expected 2", rdIdx, posCnt - drvQ[rdIdx]);
        end
        checks++;
        if ({result, flagOvf, flagUnf, flagInv, flagInx} !== expQ[rdIdx]) begin
          fails++;
          $display("FAIL %s vector %0d: actual %h/%b expected %h/%b", tagQ[rdIdx], rdIdx,
                   result, {flagOvf, flagUnf, flagInv, flagInx}, expQ[rdIdx][35:4], expQ[rdIdx][3:0]);
        end
        rdIdx++;
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] a, b;
    logic s;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if ({outVld, result, flagOvf, flagUnf, flagInv, flagInx} !== 37'd0) begin
      fails++;
      $display("FAIL R13 reset state: actual %h expected 0", {outVld, result, flagOvf, flagUnf, flagInv, flagInx});
    end

    issue(32'h3F800000, 32'h3F800000, 1'b0, {32'h40000000, 4'b0000}, "R1");
    issue(32'h41CC0000, 32'hC27D0000, 1'b0, {32'hC2170000, 4'b0000}, "R5");
    issue(32'h40400000, 32'h3F800000, 1'b1, {32'h40000000, 4'b0000}, "R2");
    issue(32'h3F800000, 32'h3F800000, 1'b1, {32'h00000000, 4'b0000}, "R6");
    issue(32'h80000000, 32'h80000000, 1'b0, {32'h80000000, 4'b0000}, "R6");
    issue(32'h3F800000, 32'h33800000, 1'b0, {32'h3F800000, 4'b0001}, "R3");
    issue(32'h3F800001, 32'h33800000, 1'b0, {32'h3F800002, 4'b0001}, "R3");
    issue(32'h3FFFFFFF, 32'h33800000, 1'b0, {32'h40000000, 4'b0001}, "R4");
    idle();
    issue(32'h7F800000, 32'h7F800000, 1'b1, {32'h7FC00000, 4'b0010}, "R8");
    issue(32'h7F800001, 32'h3F800000, 1'b0, {32'h7FC00000, 4'b0000}, "R7");
    issue(32'h7F800000, 32'hBF800000, 1'b0, {32'h7F800000, 4'b0000}, "R9");
    issue(32'h3F800000, 32'h7F800000, 1'b1, {32'hFF800000, 4'b0000}, "R9");
    issue(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, {32'h7F800000, 4'b1001}, "R10");
    issue(32'h00800001, 32'h00800000, 1'b1, {32'h00000000, 4'b0101}, "R11");
    issue(32'h00000001, 32'h3F800000, 1'b0, {32'h3F800000, 4'b0000}, "R11");
    idle(); idle();

    for (int n = 0; n < 2000; n++) begin
      a = $urandom();
      if (a[30:23] == 8'hFF) a[30:23] = 8'hFE;
      case ($urandom_range(0, 3))
        0: b = $urandom();
        1: begin b = $urandom(); b[30:23] = a[30:23]; b[22:0] = a[22:0] ^ 23'($urandom_range(0, 7)); end
        default: begin
          b = $urandom();
          b[30:23] = 8'(a[30:23] - 8'($urandom_range(0, 30)) + 8'd2);
        end
      endcase
      s = 1'($urandom());
      issue(a, b, s, refAdd(a, b, s), s ? "R2" : "R1");
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle(); idle(); idle(); idle();
    checks++;
    if (rdIdx != wrIdx) begin
      fails++;
      $display("FAIL R12 result count: actual %0d expected %0d", rdIdx, wrIdx);
    end
    finishRun();
  end
endmodule